// File: doc/BRIEF.md
# Compartment Access Filter with Per-Resource Semaphores

This block decides, for each of six resources of a memory-controller peripheral, whether a given requester may use that resource. Every requester presents a 3-bit compartment identifier (CID) and a secure/non-secure attribute. Resource 0 is the shared configuration register, resources 1 to 4 are the four chip-select controllers, and resource 5 is the NAND controller.

The rules are set through a small 32-bit register port with APB-style `psel`/`penable` framing. Each access completes in its access phase. The port holds three kinds of register per resource: a secure-only flag, a filter configuration, and a hardware semaphore that records which CID owns it. A separate combinational query port answers grant or deny for a (resource, CID, secure) triple.

Decisions follow a fixed order:
1. The secure flag is checked first.
2. Then the filter enable is checked.
3. Then either the static single-CID rule or the pass-list-plus-semaphore rule applies.

A read-only status register shows the peripheral's isolation state.

Top module: `cid_filter`

## Requirements
- R1: After reset every security, filter and semaphore register reads 0, and with filtering off any query to a valid resource is granted.
- R2: When bit i of the security register (offset 0x300) is set, a non-secure query to resource i is denied; a secure query continues to the later checks.
- R3: When bit 0 of resource i's filter register (offset 0x30C + 8·i) is clear, every CID is granted resource i.
- R4: With bit 0 set and bit 1 clear, only the CID held in bits 6:4 of the filter register is granted.
- R5: With bits 0 and 1 both set, a CID whose pass bit (bit 16 + CID, bits 23:16) is clear is denied, and its semaphore acquire attempts have no effect.
- R6: A passed CID that writes 1 to bit 0 of a free semaphore register (offset 0x310 + 8·i) takes it: bit 0 reads 1 and bits 7:5 read the writer's CID.
- R7: In semaphore mode, only the CID recorded as owner is granted, and only while the semaphore is held.
- R8: An acquire attempt on a semaphore held by another CID, or a release attempt by a non-owner, leaves the semaphore register unchanged.
- R9: The owner writing 0 to bit 0 releases the semaphore: the register reads 0.
- R10: The status register at offset 0x84 returns the 2-bit isolation state input in bits 1:0; other bits read 0.
- R11: A query with a resource index of 6 or 7 is always denied.
- R12: A non-secure write to the security or filter registers sets `pslverr` and changes nothing. Any access to an unmapped offset, or any write to the status register, sets `pslverr`. Filter register reads show only bits 0, 1, 6:4 and 23:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| bus_cid | input | 3 | CID of the register-port master |
| bus_secure | input | 1 | Register-port master is secure |
| prdata | output | 32 | Read data, valid in the access phase |
| pslverr | output | 1 | Access error, valid in the access phase |
| iso_state | input | 2 | Isolation state shown in the status register |
| use_res | input | 3 | Queried resource index |
| use_cid | input | 3 | Queried CID |
| use_secure | input | 1 | Queried requester is secure |
| use_grant | output | 1 | 1 = query granted |

## Verification
Directed steps drive each resource through the three decision modes, and each step is chosen to separate one stage of the order from the next. Examples: a secure flag set on a resource whose filter is off, a static CID that differs from the querier's, and a pass-listed CID that does not own the semaphore. Semaphore tests cover acquires and releases by the owner, by a second passed CID and by a non-passed CID, which separates the owner-match rule from the pass-list rule. Seeded random writes then mix configuration changes and secure/non-secure masters with contending semaphore writes. Queries over all eight index values, including 6 and 7, are compared against a bench model of the rules.

// File: rtl/cid_filter_pkg.sv
// Shared types and field positions for the compartment access filter.
// Assumes a 3-bit CID; the pass-list field holds one bit per CID value.
package cid_filter_pkg;
    localparam int CID_W   = 3;
    localparam int NUM_CID = 1 << CID_W;

    // Field positions that software decodes
    localparam int FEN_BIT  = 0;
    localparam int SEMM_BIT = 1;
    localparam int FCID_LSB = 4;
    localparam int PASS_LSB = 16;
    localparam int OWN_LSB  = 5;

    typedef logic [CID_W-1:0] cid_t;

    typedef struct packed {
        logic [NUM_CID-1:0] pass_list;
        cid_t               fixed_cid;
        logic               sem_mode;
        logic               filt_en;
    } cid_cfg_t;

    // Extract a configuration from a 32-bit write word
    function automatic cid_cfg_t cfg_from_word(input logic [31:0] w);
        cid_cfg_t c;
        c.filt_en   = w[FEN_BIT];
        c.sem_mode  = w[SEMM_BIT];
        c.fixed_cid = w[FCID_LSB +: CID_W];
        c.pass_list = w[PASS_LSB +: NUM_CID];
        return c;
    endfunction

    // Build the 32-bit read word of a configuration
    function automatic logic [31:0] word_from_cfg(input cid_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[FEN_BIT]             = c.filt_en;
        w[SEMM_BIT]            = c.sem_mode;
        w[FCID_LSB +: CID_W]   = c.fixed_cid;
        w[PASS_LSB +: NUM_CID] = c.pass_list;
        return w;
    endfunction
endpackage

// File: rtl/cid_sem_cell.sv
// One hardware semaphore: a held flag plus the CID of its owner.
// Assumes the register block raises wr_en only for writes to this cell's
// offset and computes 'eligible' (security, filter mode and pass list).
module cid_sem_cell
    import cid_filter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  cid_t wr_cid,
    input  logic eligible,
    output logic held,
    output cid_t owner
);
    logic acq_fire;
    logic rel_fire;

    // Acquire needs a free semaphore and a passed writer; release needs the owner
    always_comb begin
        acq_fire = wr_en && wr_bit && !held && eligible;
        rel_fire = wr_en && !wr_bit && held && (owner == wr_cid);
    end

    // Semaphore state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held  <= 1'b0;
            owner <= '0;
        end else if (acq_fire) begin
            held  <= 1'b1;
            owner <= wr_cid;
        end else if (rel_fire) begin
            held  <= 1'b0;
            owner <= '0;
        end
    end

    // R6
    acquire_records_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_fire |=> (held && owner == $past(wr_cid)));

    // R9
    release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_fire |=> !held);

    // R8
    owner_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !rel_fire) |=> (held && $stable(owner)));
endmodule

// File: rtl/cid_filter_regs.sv
// Register port: address decode, security and filter registers, semaphore
// cells and read mux. Assumes every access completes in its access phase.
module cid_filter_regs
    import cid_filter_pkg::*;
#(
    parameter int NUM_RES = 6,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [31:0]        pwdata,
    input  cid_t               bus_cid,
    input  logic               bus_secure,
    input  logic [1:0]         iso_state,
    output logic [31:0]        prdata,
    output logic               pslverr,
    output logic [NUM_RES-1:0] res_secure,
    output cid_cfg_t           cfg [NUM_RES],
    output logic [NUM_RES-1:0] sem_held,
    output cid_t               sem_owner [NUM_RES]
);
    localparam int STAT_OFS = 'h084;
    localparam int SEC_OFS  = 'h300;
    localparam int CFG_BASE = 'h30C;
    localparam int SEM_BASE = 'h310;
    localparam int STRIDE   = 8;

    logic               access;
    logic               wr;
    logic               hit_stat;
    logic               hit_sec;
    logic [NUM_RES-1:0] hit_cfg;
    logic [NUM_RES-1:0] hit_sem;
    logic               any_hit;

    // Decode the offset into one register select
    always_comb begin
        access   = psel && penable;
        wr       = access && pwrite;
        hit_stat = (paddr == ADDR_W'(STAT_OFS));
        hit_sec  = (paddr == ADDR_W'(SEC_OFS));
        for (int i = 0; i < NUM_RES; i++) begin
            hit_cfg[i] = (paddr == ADDR_W'(CFG_BASE + STRIDE * i));
            hit_sem[i] = (paddr == ADDR_W'(SEM_BASE + STRIDE * i));
        end
        any_hit = hit_stat || hit_sec || (|hit_cfg) || (|hit_sem);
    end

    // Error on unmapped offsets, status writes and non-secure config writes
    always_comb begin
        pslverr = access && (!any_hit
                             || (pwrite && hit_stat)
                             || (pwrite && !bus_secure && (hit_sec || (|hit_cfg))));
    end

    // Security register: written by secure masters only
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_secure <= '0;
        else if (wr && hit_sec && bus_secure)
            res_secure <= pwdata[NUM_RES-1:0];
    end

    for (genvar g = 0; g < NUM_RES; g++) begin : g_res
        logic eligible;

        // Filter register of resource g: written by secure masters only
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg[g] <= '0;
            else if (wr && hit_cfg[g] && bus_secure)
                cfg[g] <= cfg_from_word(pwdata);
        end

        // A writer may take the semaphore if it passes every stage but ownership
        always_comb begin
            eligible = !(res_secure[g] && !bus_secure)
                       && cfg[g].filt_en && cfg[g].sem_mode
                       && cfg[g].pass_list[bus_cid];
        end

        cid_sem_cell u_sem (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr && hit_sem[g]),
            .wr_bit   (pwdata[0]),
            .wr_cid   (bus_cid),
            .eligible (eligible),
            .held     (sem_held[g]),
            .owner    (sem_owner[g])
        );
    end

    // Read data mux
    always_comb begin
        prdata = '0;
        if (hit_stat)
            prdata[1:0] = iso_state;
        if (hit_sec)
            prdata[NUM_RES-1:0] = res_secure;
        for (int i = 0; i < NUM_RES; i++) begin
            if (hit_cfg[i])
                prdata = word_from_cfg(cfg[i]);
            if (hit_sem[i]) begin
                prdata[0]                = sem_held[i];
                prdata[OWN_LSB +: CID_W] = sem_owner[i];
            end
        end
    end

    // R12
    nonsecure_sec_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !bus_secure) |=> $stable(res_secure));
endmodule

// File: rtl/cid_filter_decide.sv
// Combinational grant decision for one query. Each resource evaluates the
// fixed order (secure flag, filter enable, static or semaphore mode) and the
// queried index picks one result; indices beyond NUM_RES are denied.
module cid_filter_decide
    import cid_filter_pkg::*;
#(
    parameter int NUM_RES = 6,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_RES-1:0] res_secure,
    input  cid_cfg_t           cfg [NUM_RES],
    input  logic [NUM_RES-1:0] sem_held,
    input  cid_t               sem_owner [NUM_RES],
    input  logic [IDX_W-1:0]   req_res,
    input  cid_t               req_cid,
    input  logic               req_secure,
    output logic               grant
);
    logic [NUM_RES-1:0] ok_vec;

    for (genvar g = 0; g < NUM_RES; g++) begin : g_chk
        logic ok;

        // Ordered decision for resource g
        always_comb begin
            if (res_secure[g] && !req_secure)
                ok = 1'b0;
            else if (!cfg[g].filt_en)
                ok = 1'b1;
            else if (!cfg[g].sem_mode)
                ok = (req_cid == cfg[g].fixed_cid);
            else
                ok = cfg[g].pass_list[req_cid] && sem_held[g]
                     && (sem_owner[g] == req_cid);
        end

        assign ok_vec[g] = ok;
    end

    // Pick the queried resource; unmatched indices stay denied
    always_comb begin
        grant = 1'b0;
        for (int i = 0; i < NUM_RES; i++)
            if (int'(req_res) == i)
                grant = ok_vec[i];
    end
endmodule

// File: rtl/cid_filter.sv
// Top of the compartment access filter: register block plus query decision.
// Assumes the query inputs are stable when use_grant is sampled.
module cid_filter
    import cid_filter_pkg::*;
#(
    parameter int NUM_RES = 6,
    parameter int ADDR_W  = 12,
    parameter int IDX_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic [CID_W-1:0]  bus_cid,
    input  logic              bus_secure,
    output logic [31:0]       prdata,
    output logic              pslverr,
    input  logic [1:0]        iso_state,
    input  logic [IDX_W-1:0]  use_res,
    input  logic [CID_W-1:0]  use_cid,
    input  logic              use_secure,
    output logic              use_grant
);
    logic [NUM_RES-1:0] res_secure;
    cid_cfg_t           cfg [NUM_RES];
    logic [NUM_RES-1:0] sem_held;
    cid_t               sem_owner [NUM_RES];
    logic               q_in_range;
    logic               q_sec_flag;

    cid_filter_regs #(.NUM_RES(NUM_RES), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .bus_cid    (bus_cid),
        .bus_secure (bus_secure),
        .iso_state  (iso_state),
        .prdata     (prdata),
        .pslverr    (pslverr),
        .res_secure (res_secure),
        .cfg        (cfg),
        .sem_held   (sem_held),
        .sem_owner  (sem_owner)
    );

    cid_filter_decide #(.NUM_RES(NUM_RES), .IDX_W(IDX_W)) u_decide (
        .res_secure (res_secure),
        .cfg        (cfg),
        .sem_held   (sem_held),
        .sem_owner  (sem_owner),
        .req_res    (use_res),
        .req_cid    (use_cid),
        .req_secure (use_secure),
        .grant      (use_grant)
    );

    // Query facts used only by the checks below
    always_comb begin
        q_in_range = (int'(use_res) < NUM_RES);
        q_sec_flag = 1'b0;
        for (int i = 0; i < NUM_RES; i++)
            if (int'(use_res) == i)
                q_sec_flag = res_secure[i];
    end

    // R11
    out_of_range_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_in_range |-> !use_grant);

    // R2
    secure_flag_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_sec_flag && !use_secure) |-> !use_grant);
endmodule

// File: tb/cid_filter_tb.sv
module cid_filter_tb_top;
    localparam int NR = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [2:0]  bus_cid = '0;
    logic        bus_secure = 1'b0;
    logic [31:0] prdata;
    logic        pslverr;
    logic [1:0]  iso_state = '0;
    logic [2:0]  use_res = '0, use_cid = '0;
    logic        use_secure = 1'b0;
    logic        use_grant;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench model of the register state
    logic [NR-1:0] m_sec;
    logic [31:0]   m_cfg [NR];
    logic          m_held [NR];
    logic [2:0]    m_own [NR];

    always #4 clk = ~clk;

    cid_filter dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .bus_cid(bus_cid), .bus_secure(bus_secure),
        .prdata(prdata), .pslverr(pslverr), .iso_state(iso_state),
        .use_res(use_res), .use_cid(use_cid), .use_secure(use_secure),
        .use_grant(use_grant)
    );

    function automatic logic [11:0] cfg_addr(int i); return 12'(12'h30C + 8 * i); endfunction
    function automatic logic [11:0] sem_addr(int i); return 12'(12'h310 + 8 * i); endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected grant from the requirements (R2..R5, R7, R11)
    function automatic bit exp_grant(int r, logic [2:0] c, bit s);
        logic [31:0] w;
        if (r >= NR) return 0;
        if (m_sec[r] && !s) return 0;
        w = m_cfg[r];
        if (!w[0]) return 1;
        if (!w[1]) return (w[6:4] == c);
        return w[16 + c] && m_held[r] && (m_own[r] == c);
    endfunction

    // Expected error and read data for an offset (R10, R12)
    function automatic bit exp_err(logic [11:0] a, bit wrt, bit s);
        if (a == 12'h084) return wrt;
        if (a == 12'h300) return wrt && !s;
        for (int i = 0; i < NR; i++) begin
            if (a == cfg_addr(i)) return wrt && !s;
            if (a == sem_addr(i)) return 0;
        end
        return 1;
    endfunction

    function automatic logic [31:0] exp_rd(logic [11:0] a);
        if (a == 12'h084) return {30'b0, iso_state};
        if (a == 12'h300) return {26'b0, m_sec};
        for (int i = 0; i < NR; i++) begin
            if (a == cfg_addr(i)) return m_cfg[i];
            if (a == sem_addr(i)) return {24'b0, m_own[i], 4'b0, m_held[i]};
        end
        return 32'h0;
    endfunction

    // Apply a write to the model (R6, R8, R9, R12)
    task automatic model_wr(logic [11:0] a, logic [31:0] d, logic [2:0] c, bit s);
        if (a == 12'h300 && s) m_sec = d[NR-1:0];
        for (int i = 0; i < NR; i++) begin
            if (a == cfg_addr(i) && s) m_cfg[i] = d & 32'h00FF_0073;
            if (a == sem_addr(i)) begin
                bit elig;
                elig = !(m_sec[i] && !s) && m_cfg[i][0] && m_cfg[i][1] && m_cfg[i][16 + c];
                if (d[0] && !m_held[i] && elig) begin
                    m_held[i] = 1; m_own[i] = c;
                end else if (!d[0] && m_held[i] && m_own[i] == c) begin
                    m_held[i] = 0; m_own[i] = 0;
                end
            end
        end
    endtask

    // One register access; checks pslverr and, on reads, prdata
    task automatic bus(input bit wrt, input logic [11:0] a, input logic [31:0] d,
                       input logic [2:0] c, input bit s, input string req);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = wrt; paddr = a; pwdata = d; bus_cid = c; bus_secure = s;
        @(negedge clk);
        penable = 1;
        #1;
        check(pslverr == exp_err(a, wrt, s), req, {31'b0, pslverr}, {31'b0, exp_err(a, wrt, s)});
        if (!wrt) check(prdata == exp_rd(a), req, prdata, exp_rd(a));
        @(negedge clk);
        psel = 0; penable = 0;
        if (wrt) model_wr(a, d, c, s);
    endtask

    task automatic query(input int r, input logic [2:0] c, input bit s, input string req);
        use_res = 3'(r); use_cid = c; use_secure = s;
        #1;
        check(use_grant == exp_grant(r, c, s), req, {31'b0, use_grant}, {31'b0, exp_grant(r, c, s)});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        m_sec = '0;
        for (int i = 0; i < NR; i++) begin m_cfg[i] = 0; m_held[i] = 0; m_own[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        bus(0, 12'h300, 0, 0, 1, "R1");
        bus(0, cfg_addr(0), 0, 0, 1, "R1");
        bus(0, sem_addr(1), 0, 0, 1, "R1");
        query(3, 5, 0, "R1");
        // R3: filter off grants any CID
        query(4, 7, 0, "R3");
        // R10: status register
        iso_state = 2'd2;
        bus(0, 12'h084, 0, 0, 0, "R10");
        // R12: rejected writes and unmapped offset
        bus(1, 12'h300, 32'h3F, 1, 0, "R12");
        bus(0, 12'h300, 0, 0, 0, "R12");
        bus(0, 12'h200, 0, 0, 1, "R12");
        bus(1, 12'h084, 1, 0, 1, "R12");
        bus(1, cfg_addr(2), 32'hFFFF_FFFF, 0, 1, "R12");
        bus(0, cfg_addr(2), 0, 0, 0, "R12");
        bus(1, cfg_addr(2), 0, 0, 1, "R12");
        // R2: secure flag on resource 2
        bus(1, 12'h300, 32'h04, 0, 1, "R2");
        query(2, 1, 0, "R2");
        query(2, 1, 1, "R2");
        query(3, 1, 0, "R2");
        // R4: static CID 1 on resource 1
        bus(1, cfg_addr(1), 32'h11, 0, 1, "R4");
        query(1, 1, 0, "R4");
        query(1, 2, 0, "R4");
        // R5/R6/R7: semaphore mode on resource 3, pass list {1,4}
        bus(1, cfg_addr(3), 32'h0012_0003, 0, 1, "R5");
        query(3, 1, 0, "R7");
        bus(1, sem_addr(3), 1, 2, 0, "R5");
        bus(0, sem_addr(3), 0, 2, 0, "R5");
        query(3, 2, 0, "R5");
        bus(1, sem_addr(3), 1, 1, 0, "R6");
        bus(0, sem_addr(3), 0, 1, 0, "R6");
        query(3, 1, 0, "R7");
        query(3, 4, 0, "R7");
        // R8: contention by CID 4
        bus(1, sem_addr(3), 1, 4, 0, "R8");
        bus(1, sem_addr(3), 0, 4, 0, "R8");
        bus(0, sem_addr(3), 0, 4, 0, "R8");
        // R9: release by owner, then CID 4 takes it
        bus(1, sem_addr(3), 0, 1, 0, "R9");
        bus(0, sem_addr(3), 0, 1, 0, "R9");
        bus(1, sem_addr(3), 1, 4, 0, "R6");
        bus(0, sem_addr(3), 0, 4, 0, "R6");
        query(3, 4, 0, "R7");
        // R11: indices beyond the last resource
        query(6, 0, 1, "R11");
        query(7, 1, 1, "R11");

        // Seeded random mix
        for (int it = 0; it < 400; it++) begin
            int kind, r;
            logic [31:0] d;
            logic [2:0] c;
            bit s;
            kind = int'($urandom % 4);
            r = int'($urandom % NR);
            c = 3'($urandom);
            s = ($urandom % 4) != 0;
            d = $urandom;
            case (kind)
                0: bus(1, 12'h300, d & 32'h3F & 32'($urandom), c, s, "R2");
                1: bus(1, cfg_addr(r), d | 32'h1, c, s, "R4");
                default: bus(1, sem_addr(r), {31'b0, d[0]}, c, ($urandom % 8) != 0, "R8");
            endcase
            bus(0, sem_addr(r), 0, c, s, "R6");
            for (int q = 0; q < 3; q++)
                query(int'($urandom % 8), 3'($urandom), $urandom % 2 == 1, "R7");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule